// File: doc/BRIEF.md
# Embedded Video Sync Code Detector

This block watches an 8-bit video byte stream and recovers line and frame timing from synchronization words carried inside the data. There are no separate sync wires. A byte counts only on a clock edge where the pixel-clock enable is high.

A synchronization word is four bytes long: 0xFF, 0x00, 0x00, then a code byte. The code byte is compared against four configurable values: frame end, frame start, line end and line start. Each value has its own unmask byte. Only the bits set in that unmask byte take part in the comparison.

The detector locks onto a frame only when a frame-start word arrives after a frame-end word has been seen. While locked, it raises a line level between line-start and line-end words. It then flags each byte inside the line as pixel data. Configuration arrives on plain input ports. When the enable is low, the block holds itself cleared.

Top module: `sync_code_det`

## Requirements
- R1: After reset, and one cycle after any edge with `en_i` low, all pulses, `frame_valid_o`, `line_valid_o` and `pix_valid_o` are 0. Bytes presented while disabled produce no detection.
- R2: The sequence 0xFF, 0x00, 0x00, C on consecutive enabled bytes is a detection when C matches a code. The matching pulse is high for exactly one cycle, in the cycle after the edge that samples C.
- R3: A code matches when `((C ^ code) & mask) == 0`. With code 0xA5 and mask 0xF0 the byte 0xA6 matches; with mask 0xFF it does not.
- R4: When several codes match one code byte, only one pulse fires. The priority is frame end, then frame start, then line end, then line start.
- R5: `frame_valid_o` rises only with a frame-start detection that follows a frame-end detection. A frame start seen with no frame end before it leaves `frame_valid_o` low.
- R6: A frame-end detection drops `frame_valid_o` and `line_valid_o` in the same cycle as the frame-end pulse.
- R7: A line-start detection raises `line_valid_o` only while `frame_valid_o` is high. A line-end detection lowers it.
- R8: `pix_valid_o` is high, with the byte on `pix_data_o`, one cycle after an enabled byte that is neither 0xFF, 0x00 nor a code byte, and only while both levels are high.
- R9: A byte that breaks the preamble returns the search to idle. A 0xFF in any position restarts the search, so 0xFF, 0xFF, 0x00, 0x00, C is still detected.
- R10: Edges with `pix_ce_i` low neither advance nor reset the preamble search, and they produce no pulse and no pixel strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Detector enable; low clears all state |
| pix_ce_i | input | 1 | Byte-valid enable for `pix_data_i` |
| pix_data_i | input | 8 | Incoming stream byte |
| code_ls_i | input | 8 | Line-start code byte |
| code_le_i | input | 8 | Line-end code byte |
| code_fs_i | input | 8 | Frame-start code byte |
| code_fe_i | input | 8 | Frame-end code byte |
| mask_ls_i | input | 8 | Compare mask for line start |
| mask_le_i | input | 8 | Compare mask for line end |
| mask_fs_i | input | 8 | Compare mask for frame start |
| mask_fe_i | input | 8 | Compare mask for frame end |
| ls_pulse_o | output | 1 | Line-start detected |
| le_pulse_o | output | 1 | Line-end detected |
| fs_pulse_o | output | 1 | Frame-start detected |
| fe_pulse_o | output | 1 | Frame-end detected |
| frame_valid_o | output | 1 | Inside a locked frame |
| line_valid_o | output | 1 | Inside an active line |
| pix_valid_o | output | 1 | `pix_data_o` holds a pixel byte |
| pix_data_o | output | 8 | Registered pixel byte |

## Verification
The stimulus mixes clean sync words, a preamble broken by a foreign byte, and a preamble with a doubled 0xFF. The first shows detection, the second shows the search resetting, and the third shows the 0xFF restart. Frame-start words are sent both before and after a frame-end word, which separates plain detection from frame lock. Pixel bytes are placed inside a line, after line end, and next to preamble bytes, so the stream is tested on both sides of every gating condition. Overlapping code values are swept from all four matching down to one matching, and masked and unmasked comparisons of the same byte expose the priority order and the bit masking.

// File: rtl/scd_pkg.sv
package scd_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned NUM_CODES = 4;
  localparam logic [BYTE_W-1:0] SYNC_HI = 8'hFF;
  localparam logic [BYTE_W-1:0] SYNC_LO = 8'h00;

  typedef enum logic [1:0] {
    PRE_IDLE,
    PRE_HI,
    PRE_LO1,
    PRE_LO2
  } pre_state_e;

  // index order is also priority order: higher index wins
  typedef enum int unsigned {
    CODE_LS = 0,
    CODE_LE = 1,
    CODE_FS = 2,
    CODE_FE = 3
  } code_idx_e;

  typedef logic [NUM_CODES-1:0][BYTE_W-1:0] code_vec_t;
endpackage

// File: rtl/scd_preamble.sv
module scd_preamble
  import scd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ce_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              code_slot_o,
  output logic              sync_byte_o
);
  pre_state_e state_q, state_d;
  logic is_hi, is_lo;

  assign is_hi = (byte_i == SYNC_HI);
  assign is_lo = (byte_i == SYNC_LO);

  always_comb begin
    state_d = state_q;
    if (is_hi) begin
      state_d = PRE_HI;
    end else begin
      unique case (state_q)
        PRE_HI:  state_d = is_lo ? PRE_LO1 : PRE_IDLE;
        PRE_LO1: state_d = is_lo ? PRE_LO2 : PRE_IDLE;
        default: state_d = PRE_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= PRE_IDLE;
    else if (!en_i) state_q <= PRE_IDLE;
    else if (ce_i)  state_q <= state_d;
  end

  assign code_slot_o = (state_q == PRE_LO2);
  assign sync_byte_o = is_hi | is_lo;
endmodule

// File: rtl/scd_code_match.sv
module scd_code_match
  import scd_pkg::*;
(
  input  logic [BYTE_W-1:0]    byte_i,
  input  code_vec_t            code_i,
  input  code_vec_t            mask_i,
  output logic [NUM_CODES-1:0] sel_o
);
  logic [NUM_CODES-1:0] hit;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_cmp
    assign hit[g] = ((byte_i ^ code_i[g]) & mask_i[g]) == '0;
  end

  always_comb begin
    sel_o = '0;
    for (int i = NUM_CODES - 1; i >= 0; i--) begin
      if (hit[i] && sel_o == '0) sel_o[i] = 1'b1;
    end
  end
endmodule

// File: rtl/scd_timing.sv
module scd_timing
  import scd_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 ce_i,
  input  logic                 code_slot_i,
  input  logic                 sync_byte_i,
  input  logic [NUM_CODES-1:0] sel_i,
  input  logic [BYTE_W-1:0]    byte_i,
  output logic [NUM_CODES-1:0] pulse_o,
  output logic                 frame_valid_o,
  output logic                 line_valid_o,
  output logic                 pix_valid_o,
  output logic [BYTE_W-1:0]    pix_data_o
);
  logic [NUM_CODES-1:0] det;
  logic                 armed_q, frame_q, line_q, pix_q;
  logic [NUM_CODES-1:0] pulse_q;
  logic [BYTE_W-1:0]    data_q;

  assign det = code_slot_i ? sel_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      frame_q <= 1'b0;
      line_q  <= 1'b0;
      pix_q   <= 1'b0;
      pulse_q <= '0;
      data_q  <= '0;
    end else if (!en_i) begin
      armed_q <= 1'b0;
      frame_q <= 1'b0;
      line_q  <= 1'b0;
      pix_q   <= 1'b0;
      pulse_q <= '0;
    end else begin
      pulse_q <= '0;
      pix_q   <= 1'b0;
      if (ce_i) begin
        pulse_q <= det;
        if (det[CODE_FE]) begin
          frame_q <= 1'b0;
          line_q  <= 1'b0;
          armed_q <= 1'b1;
        end else if (det[CODE_FS]) begin
          if (armed_q) begin
            frame_q <= 1'b1;
            armed_q <= 1'b0;
          end
        end else if (det[CODE_LE]) begin
          line_q <= 1'b0;
        end else if (det[CODE_LS]) begin
          if (frame_q) line_q <= 1'b1;
        end
        pix_q  <= frame_q & line_q & ~sync_byte_i & ~code_slot_i;
        data_q <= byte_i;
      end
    end
  end

  assign pulse_o       = pulse_q;
  assign frame_valid_o = frame_q;
  assign line_valid_o  = line_q;
  assign pix_valid_o   = pix_q;
  assign pix_data_o    = data_q;
endmodule

// File: rtl/sync_code_det.sv
module sync_code_det
  import scd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              pix_ce_i,
  input  logic [BYTE_W-1:0] pix_data_i,
  input  logic [BYTE_W-1:0] code_ls_i,
  input  logic [BYTE_W-1:0] code_le_i,
  input  logic [BYTE_W-1:0] code_fs_i,
  input  logic [BYTE_W-1:0] code_fe_i,
  input  logic [BYTE_W-1:0] mask_ls_i,
  input  logic [BYTE_W-1:0] mask_le_i,
  input  logic [BYTE_W-1:0] mask_fs_i,
  input  logic [BYTE_W-1:0] mask_fe_i,
  output logic              ls_pulse_o,
  output logic              le_pulse_o,
  output logic              fs_pulse_o,
  output logic              fe_pulse_o,
  output logic              frame_valid_o,
  output logic              line_valid_o,
  output logic              pix_valid_o,
  output logic [BYTE_W-1:0] pix_data_o
);
  code_vec_t            codes, masks;
  logic                 code_slot, sync_byte;
  logic [NUM_CODES-1:0] sel, pulses;

  always_comb begin
    codes[CODE_LS] = code_ls_i;
    codes[CODE_LE] = code_le_i;
    codes[CODE_FS] = code_fs_i;
    codes[CODE_FE] = code_fe_i;
    masks[CODE_LS] = mask_ls_i;
    masks[CODE_LE] = mask_le_i;
    masks[CODE_FS] = mask_fs_i;
    masks[CODE_FE] = mask_fe_i;
  end

  scd_preamble u_pre (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .ce_i        (pix_ce_i),
    .byte_i      (pix_data_i),
    .code_slot_o (code_slot),
    .sync_byte_o (sync_byte)
  );

  scd_code_match u_match (
    .byte_i (pix_data_i),
    .code_i (codes),
    .mask_i (masks),
    .sel_o  (sel)
  );

  scd_timing u_tim (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .ce_i          (pix_ce_i),
    .code_slot_i   (code_slot),
    .sync_byte_i   (sync_byte),
    .sel_i         (sel),
    .byte_i        (pix_data_i),
    .pulse_o       (pulses),
    .frame_valid_o (frame_valid_o),
    .line_valid_o  (line_valid_o),
    .pix_valid_o   (pix_valid_o),
    .pix_data_o    (pix_data_o)
  );

  assign ls_pulse_o = pulses[CODE_LS];
  assign le_pulse_o = pulses[CODE_LE];
  assign fs_pulse_o = pulses[CODE_FS];
  assign fe_pulse_o = pulses[CODE_FE];
endmodule

// File: rtl/scd_checker.sv
module scd_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       pix_ce_i,
  input logic       ls_pulse_o,
  input logic       le_pulse_o,
  input logic       fs_pulse_o,
  input logic       fe_pulse_o,
  input logic       frame_valid_o,
  input logic       line_valid_o,
  input logic       pix_valid_o,
  input logic [7:0] pix_data_o
);
  logic [3:0] pul;
  assign pul = {fe_pulse_o, fs_pulse_o, le_pulse_o, ls_pulse_o};

  AST_PULSE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pul)); // R4
  AST_PULSE_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pul != 4'b0) |=> (pul == 4'b0)); // R2
  AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pul == 4'b0 && !frame_valid_o && !line_valid_o && !pix_valid_o)); // R1
  AST_FRAME_RISE_FS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_valid_o) |-> fs_pulse_o); // R5
  AST_FE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fe_pulse_o |-> (!frame_valid_o && !line_valid_o)); // R6
  AST_LINE_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |-> frame_valid_o); // R7
  AST_PIX_IN_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (line_valid_o && frame_valid_o)); // R8
  AST_PIX_NOT_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (pix_data_o != 8'hFF && pix_data_o != 8'h00)); // R8
  AST_IDLE_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_ce_i |=> (pul == 4'b0 && !pix_valid_o)); // R10
endmodule

bind sync_code_det scd_checker u_scd_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .en_i          (en_i),
  .pix_ce_i      (pix_ce_i),
  .ls_pulse_o    (ls_pulse_o),
  .le_pulse_o    (le_pulse_o),
  .fs_pulse_o    (fs_pulse_o),
  .fe_pulse_o    (fe_pulse_o),
  .frame_valid_o (frame_valid_o),
  .line_valid_o  (line_valid_o),
  .pix_valid_o   (pix_valid_o),
  .pix_data_o    (pix_data_o)
);

// File: tb/sync_code_det_bench.sv
`timescale 1ns/1ps
module sync_code_det_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, ce = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] c_ls = 8'h80, c_le = 8'h9D, c_fs = 8'hAB, c_fe = 8'hB6;
  logic [7:0] m_ls = 8'hFF, m_le = 8'hFF, m_fs = 8'hFF, m_fe = 8'hFF;
  logic ls_p, le_p, fs_p, fe_p, fv, lv, pv;
  logic [7:0] pd;
  int checks = 0, fails = 0;
  logic [3:0] last_p;

  always #2.5 clk = ~clk;

  sync_code_det u_sync_code_det (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pix_ce_i(ce), .pix_data_i(din),
    .code_ls_i(c_ls), .code_le_i(c_le), .code_fs_i(c_fs), .code_fe_i(c_fe),
    .mask_ls_i(m_ls), .mask_le_i(m_le), .mask_fs_i(m_fs), .mask_fe_i(m_fe),
    .ls_pulse_o(ls_p), .le_pulse_o(le_p), .fs_pulse_o(fs_p), .fe_pulse_o(fe_p),
    .frame_valid_o(fv), .line_valid_o(lv), .pix_valid_o(pv), .pix_data_o(pd)
  );

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one enabled byte at a negedge; outputs are sampled at the next negedge
  task automatic put(input logic [7:0] b);
    din = b; ce = 1'b1;
    @(negedge clk);
    ce = 1'b0;
    last_p = {fe_p, fs_p, le_p, ls_p};
  endtask

  task automatic send_code(input logic [7:0] c);
    put(8'hFF); put(8'h00); put(8'h00); put(c);
  endtask

  task automatic t_reset;
    chk("R1 reset outputs", {28'd0, ls_p, le_p, fs_p, fe_p}, 32'd0);
    chk("R1 reset levels", {29'd0, fv, lv, pv}, 32'd0);
    put(8'hFF); put(8'h00); put(8'h00); put(8'hB6);
    chk("R1 disabled no detect", {28'd0, last_p}, 32'd0);
    en = 1'b1;
  endtask

  task automatic t_lock;
    send_code(8'hAB);
    chk("R2 fs pulse", {28'd0, last_p}, 32'b0100);
    chk("R5 fs without fe no lock", {31'd0, fv}, 32'd0);
    @(negedge clk);
    chk("R2 pulse one cycle", {28'd0, fe_p, fs_p, le_p, ls_p}, 32'd0);
    send_code(8'hB6);
    chk("R2 fe pulse", {28'd0, last_p}, 32'b1000);
    send_code(8'hAB);
    chk("R5 fe then fs locks", {31'd0, fv}, 32'd1);
  endtask

  task automatic t_line;
    send_code(8'h80);
    chk("R7 ls in frame", {31'd0, lv}, 32'd1);
    put(8'h11);
    chk("R8 pixel valid", {23'd0, pv, pd}, {23'd0, 1'b1, 8'h11});
    put(8'h22);
    chk("R8 pixel data", {23'd0, pv, pd}, {23'd0, 1'b1, 8'h22});
    put(8'hFF);
    chk("R8 ff not pixel", {31'd0, pv}, 32'd0);
    put(8'h00); put(8'h00); put(8'h9D);
    chk("R8 code byte not pixel", {31'd0, pv}, 32'd0);
    chk("R7 le clears line", {31'd0, lv}, 32'd0);
    put(8'h33);
    chk("R8 no pixel after le", {31'd0, pv}, 32'd0);
    send_code(8'h80);
    send_code(8'hB6);
    chk("R6 fe drops levels with pulse", {29'd0, fe_p, fv, lv}, 32'b100);
    send_code(8'h80);
    chk("R7 ls outside frame ignored", {31'd0, lv}, 32'd0);
  endtask

  task automatic t_mask;
    c_fs = 8'hA5; m_fs = 8'hF0;
    send_code(8'hB6);
    send_code(8'hA6);
    chk("R3 masked match", {28'd0, last_p}, 32'b0100);
    chk("R3 masked match locks", {31'd0, fv}, 32'd1);
    m_fs = 8'hFF;
    send_code(8'hB6);
    send_code(8'hA6);
    chk("R3 full mask rejects", {28'd0, last_p}, 32'd0);
    c_fs = 8'hAB;
  endtask

  task automatic t_priority;
    c_ls = 8'h80; c_le = 8'h80; c_fs = 8'h80; c_fe = 8'h80;
    send_code(8'h80);
    chk("R4 fe wins", {28'd0, last_p}, 32'b1000);
    c_fe = 8'hB6;
    send_code(8'h80);
    chk("R4 fs over le ls", {28'd0, last_p}, 32'b0100);
    c_fs = 8'hAB;
    send_code(8'h80);
    chk("R4 le over ls", {28'd0, last_p}, 32'b0010);
    c_le = 8'h9D;
    send_code(8'h80);
    chk("R4 ls alone", {28'd0, last_p}, 32'b0001);
  endtask

  task automatic t_broken;
    logic [3:0] acc = '0;
    put(8'hFF); put(8'h00); acc |= last_p; put(8'h33); put(8'h00); put(8'hB6);
    acc |= last_p;
    chk("R9 broken preamble", {28'd0, acc}, 32'd0);
    put(8'hFF); put(8'hFF); put(8'h00); put(8'h00); put(8'hB6);
    chk("R9 ff restart", {28'd0, last_p}, 32'b1000);
  endtask

  task automatic t_ce;
    put(8'hFF);
    din = 8'h33; ce = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 idle ce no pulse", {28'd0, fe_p, fs_p, le_p, ls_p}, 32'd0);
    put(8'h00); put(8'h00);
    din = 8'hAB; ce = 1'b0;
    @(negedge clk);
    chk("R10 code byte with ce low ignored", {28'd0, fe_p, fs_p, le_p, ls_p}, 32'd0);
    put(8'hAB);
    chk("R10 held search completes", {28'd0, last_p}, 32'b0100);
  endtask

  task automatic t_disable;
    chk("R1 locked before disable", {31'd0, fv}, 32'd1);
    en = 1'b0;
    @(negedge clk);
    chk("R1 disable clears frame", {30'd0, fv, lv}, 32'd0);
    send_code(8'hB6);
    chk("R1 no detect while disabled", {28'd0, last_p}, 32'd0);
    en = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_line();
    t_mask();
    t_priority();
    t_broken();
    t_ce();
    t_disable();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule